// File: doc/BRIEF.md
# Eight-Function 32-bit ALU

This block is the arithmetic-logic unit of a small single-cycle processor. It accepts two operand words and a three-bit operation code. It returns a result word and a flag that is high whenever that result is all zeros. The flag feeds the branch-on-equal decision. The operations are:

- addition and subtraction;
- signed and unsigned less-than tests;
- bitwise AND, OR and NOR;
- a fixed shift of the second operand into the upper half of the word, used to load an upper immediate.

The unit is purely combinational. A surrounding datapath drives the operands and the code, and reads both outputs within the same cycle. One adder serves addition, subtraction and both comparisons. The bitwise functions and the fixed shift form a separate slice. A final stage picks the result using the code's top bit and builds the zero flag from it.

Top module: `alu_core8`

## Requirements
- R1: With op_sel = 3'b000, result equals op_a + op_b modulo 2^32, and there is no overflow output.
- R2: With op_sel = 3'b001, result equals op_a - op_b modulo 2^32.
- R3: With op_sel = 3'b010, result is 1 when op_a < op_b with both operands read as two's-complement signed values, and 0 otherwise.
- R4: With op_sel = 3'b011, result is 1 when op_a < op_b with both operands read as unsigned values, and 0 otherwise.
- R5: For op_sel 3'b010 and 3'b011, result bits 31..1 are always zero.
- R6: With op_sel = 3'b100, result is the bitwise AND of op_a and op_b. With op_sel = 3'b101, result is their bitwise OR.
- R7: With op_sel = 3'b110, result is op_b shifted left by 16 positions with zeros in bits 15..0, and op_a has no effect.
- R8: With op_sel = 3'b111, result is the bitwise NOR of op_a and op_b.
- R9: zero is 1 exactly when result is all zeros, under every op_sel value.
- R10: The block has no clock or state; both outputs follow the present inputs only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand; the source of the upper-half shift |
| op_sel | input | 3 | Operation code |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is all zeros |

## Verification
The unit holds no state, so any internal fault shows at result or zero as soon as the inputs settle. It never appears cycles later. An inverted carry or overflow term in the shared adder shows up only in some cases:

- A signed-compare fault corrupts results only when the operand signs differ, or when the subtraction overflows.
- An unsigned-compare fault shows up when exactly one operand has its top bit set.

The bench therefore aims its directed patterns at those sign boundaries, at equal operands, and at the extreme values. It checks zero against the same sample of result, because a wrong zero flag would mislead branch decisions while result still looks correct.

// File: rtl/alu_pkg.sv
// Package: shared operation codes and widths for the eight-function ALU.
// Assumes the code values are fixed by the instruction decoder upstream.
package alu_pkg;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned SEL_W  = 3;

    typedef enum logic [SEL_W-1:0] {
        OP_ADD  = 3'b000,
        OP_SUB  = 3'b001,
        OP_SLTS = 3'b010,
        OP_SLTU = 3'b011,
        OP_AND  = 3'b100,
        OP_OR   = 3'b101,
        OP_HISH = 3'b110,
        OP_NOR  = 3'b111
    } alu_op_e;
endpackage

// File: rtl/alu_addsub.sv
// Module: shared adder that adds or subtracts, and derives both less-than flags.
// Assumes the flags are consumed only while do_sub is high.
module alu_addsub #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         do_sub,
    output logic [W-1:0] sum,
    output logic         lt_signed,
    output logic         lt_unsigned
);
    localparam int unsigned MSB = W - 1;

    logic [W:0]   wide;
    logic [W-1:0] b_eff;
    logic         ovf;

    // Purpose: a single carry chain; the inverted operand plus the carry-in gives subtraction.
    always_comb begin
        b_eff = b ^ {W{do_sub}};
        wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, do_sub};
        sum   = wide[W-1:0];
    end

    // Purpose: derive the comparison flags from the carry-out and the sign-overflow term.
    always_comb begin
        ovf         = (a[MSB] ^ b[MSB]) & (a[MSB] ^ sum[MSB]);
        lt_signed   = sum[MSB] ^ ovf;
        lt_unsigned = ~wide[W];
    end

    // Purpose: check the carry-derived flags against direct comparisons.
    always_comb begin
        if (!$isunknown({a, b, do_sub}) && do_sub) begin
            // R3
            lt_signed_chk: assert (lt_signed == ($signed(a) < $signed(b)))
                else $error("signed less-than flag disagrees");
            // R4
            lt_unsigned_chk: assert (lt_unsigned == (a < b))
                else $error("unsigned less-than flag disagrees");
        end
    end
endmodule

// File: rtl/alu_logic.sv
// Module: bitwise functions and the fixed upper-half shift.
// Assumes only the two low bits of the code select among the four functions.
module alu_logic #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [1:0]   fn,
    output logic [W-1:0] y
);
    localparam int unsigned SHIFT_AMT = W / 2;

    // Purpose: pick one of AND, OR, upper-half shift or NOR.
    always_comb begin
        unique case (fn)
            2'b00:   y = a & b;
            2'b01:   y = a | b;
            2'b10:   y = b << SHIFT_AMT;
            default: y = ~(a | b);
        endcase
    end

    // Purpose: check the shifted value and the NOR without re-deriving them.
    always_comb begin
        if (!$isunknown({a, b, fn})) begin
            // R7
            hish_low_zero_chk: assert (fn != 2'b10 || y[SHIFT_AMT-1:0] == '0)
                else $error("upper-half shift left low bits set");
            // R8
            nor_disjoint_chk: assert (fn != 2'b11 || (((y & (a | b)) == '0) && ((y | a | b) == '1)))
                else $error("NOR result overlaps operand bits");
        end
    end
endmodule

// File: rtl/alu_core8.sv
// Module: top of the eight-function ALU. Routes the code to the adder or the logic
// slice and produces the zero flag. Purely combinational; no clock or reset.
module alu_core8
    import alu_pkg::*;
(
    input  logic [31:0] op_a,
    input  logic [31:0] op_b,
    input  logic [2:0]  op_sel,
    output logic [31:0] result,
    output logic        zero
);
    localparam int unsigned W = DATA_W;

    alu_op_e      sel;
    logic         do_sub;
    logic [W-1:0] arith_sum;
    logic         lt_s;
    logic         lt_u;
    logic [W-1:0] logic_y;

    // Purpose: decode the code; every code except addition uses the subtract path.
    always_comb begin
        sel    = alu_op_e'(op_sel);
        do_sub = (sel != OP_ADD);
    end

    alu_addsub #(.W(W)) u_addsub (
        .a           (op_a),
        .b           (op_b),
        .do_sub      (do_sub),
        .sum         (arith_sum),
        .lt_signed   (lt_s),
        .lt_unsigned (lt_u)
    );

    alu_logic #(.W(W)) u_logic (
        .a  (op_a),
        .b  (op_b),
        .fn (op_sel[1:0]),
        .y  (logic_y)
    );

    // Purpose: final result select; comparisons are zero-extended to the full width.
    always_comb begin
        unique case (sel)
            OP_ADD, OP_SUB: result = arith_sum;
            OP_SLTS:        result = {{(W-1){1'b0}}, lt_s};
            OP_SLTU:        result = {{(W-1){1'b0}}, lt_u};
            default:        result = logic_y;
        endcase
    end

    // Purpose: all-zero detect on the selected result.
    always_comb zero = ~|result;

    // Purpose: cross-check results and the flag at the top level.
    always_comb begin
        if (!$isunknown({op_a, op_b, op_sel})) begin
            // R1
            add_wrap_chk: assert (sel != OP_ADD || (result - op_b) == op_a)
                else $error("sum does not invert to operand");
            // R2
            sub_wrap_chk: assert (sel != OP_SUB || (result + op_b) == op_a)
                else $error("difference does not invert to operand");
            // R5
            slt_extend_chk: assert (!(sel == OP_SLTS || sel == OP_SLTU) || result[W-1:1] == '0)
                else $error("comparison result not zero-extended");
            // R9
            zero_eq_chk: assert (sel != OP_SUB || (op_a != op_b) || zero)
                else $error("equal operands gave no zero flag");
        end
    end
endmodule

// File: tb/tb_alu_core8.sv
module tb_alu_core8;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [2:0]  op_sel = '0;
    logic [31:0] result;
    logic        zero;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    alu_core8 dut (
        .op_a   (op_a),
        .op_b   (op_b),
        .op_sel (op_sel),
        .result (result),
        .zero   (zero)
    );

    function automatic logic [31:0] model(input logic [2:0] s, input logic [31:0] a, input logic [31:0] b);
        case (s)
            3'b000:  return a + b;
            3'b001:  return a - b;
            3'b010:  return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            3'b011:  return (a < b) ? 32'd1 : 32'd0;
            3'b100:  return a & b;
            3'b101:  return a | b;
            3'b110:  return {b[15:0], 16'h0000};
            default: return ~(a | b);
        endcase
    endfunction

    task automatic expect_val(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive, wait to the falling edge, then compare result and zero flag
    task automatic apply(input string req, input logic [2:0] s, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] exp;
        op_sel = s; op_a = a; op_b = b;
        @(negedge clk);
        exp = model(s, a, b);
        expect_val(req, result, exp);
        expect_val("R9", {31'd0, zero}, {31'd0, exp == 32'd0});
    endtask

    task automatic t_reset_state();
        apply("R1 idle zero inputs", 3'b000, 32'd0, 32'd0);
    endtask

    task automatic t_add();
        apply("R1", 3'b000, 32'h0000_0005, 32'h0000_0007);
        apply("R1 wrap", 3'b000, 32'hFFFF_FFFF, 32'h0000_0001);
        apply("R1 signed overflow", 3'b000, 32'h7FFF_FFFF, 32'h0000_0001);
    endtask

    task automatic t_sub();
        apply("R2", 3'b001, 32'd200, 32'd58);
        apply("R2 equal", 3'b001, 32'h1234_5678, 32'h1234_5678);
        apply("R2 wrap", 3'b001, 32'd0, 32'd1);
    endtask

    task automatic t_slt_signed();
        apply("R3 neg<pos", 3'b010, 32'hFFFF_FFFF, 32'h0000_0001);
        apply("R3 pos<neg", 3'b010, 32'h0000_0001, 32'hFFFF_FFFF);
        apply("R3 min<max", 3'b010, 32'h8000_0000, 32'h7FFF_FFFF);
        apply("R3 max<min", 3'b010, 32'h7FFF_FFFF, 32'h8000_0000);
        apply("R3 equal", 3'b010, 32'h8000_0000, 32'h8000_0000);
    endtask

    task automatic t_slt_unsigned();
        apply("R4 small<big", 3'b011, 32'h0000_0001, 32'hFFFF_FFFF);
        apply("R4 big<small", 3'b011, 32'hFFFF_FFFF, 32'h0000_0001);
        apply("R4 msb split", 3'b011, 32'h7FFF_FFFF, 32'h8000_0000);
        apply("R4 equal", 3'b011, 32'h0, 32'h0);
    endtask

    task automatic t_slt_extend();
        op_sel = 3'b011; op_a = 32'd0; op_b = 32'hFFFF_FFFF;
        @(negedge clk);
        expect_val("R5", {result[31:1], 1'b0}, 32'd0);
        op_sel = 3'b010; op_a = 32'hFFFF_FFFF; op_b = 32'd0;
        @(negedge clk);
        expect_val("R5", {result[31:1], 1'b0}, 32'd0);
    endtask

    task automatic t_and_or();
        apply("R6 and", 3'b100, 32'hF0F0_FF00, 32'hFF00_0FF0);
        apply("R6 and disjoint", 3'b100, 32'hAAAA_AAAA, 32'h5555_5555);
        apply("R6 or", 3'b101, 32'hF0F0_0000, 32'h0000_0F0F);
        apply("R6 or zeros", 3'b101, 32'd0, 32'd0);
    endtask

    task automatic t_hish();
        apply("R7", 3'b110, 32'hDEAD_BEEF, 32'h0000_1234);
        apply("R7 upper dropped", 3'b110, 32'h0, 32'hABCD_0000);
        apply("R7 a ignored", 3'b110, 32'hFFFF_FFFF, 32'h0000_0001);
    endtask

    task automatic t_nor();
        apply("R8", 3'b111, 32'h0, 32'h0);
        apply("R8 all ones", 3'b111, 32'hFFFF_0000, 32'h0000_FFFF);
        apply("R8 mixed", 3'b111, 32'h1234_0000, 32'h0000_00F0);
    endtask

    task automatic t_comb();
        // R10: no clock reaches the block; a change between edges shows at once
        @(posedge clk);
        #3;
        op_sel = 3'b000; op_a = 32'd40; op_b = 32'd2;
        #1;
        expect_val("R10", result, 32'd42);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_add();
        t_sub();
        t_slt_signed();
        t_slt_unsigned();
        t_slt_extend();
        t_and_or();
        t_hish();
        t_nor();
        t_comb();
        for (int s = 0; s < 8; s++) begin
            apply("R9 sweep", 3'(s), 32'h0000_8001, 32'h0000_8001);
        end
        finish_run();
    end

    initial begin
        #(20 * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule